// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Line-Break Detection

This block recovers asynchronous serial frames from a single receive line. The line is sampled on a clock-enable strobe that runs at sixteen times the bit rate. Each frame has four parts in this order: a low start bit, eight data bits with the least significant bit first, a ninth data bit, and a high stop bit. For every accepted frame the block presents the data byte and the ninth bit together with a one-cycle valid strobe. The baud source and the transmitter sit outside the block.

Two line faults are tracked in sticky status flags. The first is a stop bit that reads low, which is a framing error. The second is a line held low for eleven bit times or longer, which is a break. A break also raises a one-cycle request that a system can use to reset the device into a programming mode. The top bit of the control register can show either the framing-error flag or a mode bit that the surrounding register logic holds, depending on a routing select.

Top module: `serial_rx9_brk`

## Requirements
- R1: On each accepted frame, `rx_data[0]` holds the first data bit received and `rx_data[7]` holds the eighth. `rx_bit9` holds the bit that follows them.
- R2: `rx_valid` pulses high for exactly one clock per accepted frame, and never without a frame on the line. Frames separated by a single stop bit are all delivered.
- R3: A stop bit that votes low sets `stat_fe`, which is 1 in the same cycle as that frame's `rx_valid`. The frame is still delivered, and `stat_fe` stays set until it is cleared.
- R4: Each bit is decided by majority vote of oversample ticks 7, 8 and 9 of its sixteen ticks. A line disturbance lasting one tick in mid-bit does not change the received value.
- R5: A start bit that votes high at mid-bit is discarded as noise: no frame is delivered and the receiver hunts for a new start edge.
- R6: After 176 consecutive low oversample ticks (eleven bit times), `stat_brk` is set and `brk_req` pulses for one clock. A low period of ten bit times sets neither.
- R7: `brk_req` pulses at most once per continuous low period. Any high sample re-arms the detector for the next low period.
- R8: `ctrl_top` equals `stat_fe` when `fe_route` is 1 and equals `mode_hi` when `fe_route` is 0.
- R9: After reset all outputs are 0. A one-cycle high on `clr_fe` or `clr_brk` clears the matching flag, and a flag being set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversample enable, sixteen per bit time |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| fe_route | input | 1 | 1: control top bit shows framing error; 0: shows mode bit |
| mode_hi | input | 1 | Mode bit held by the control register |
| clr_fe | input | 1 | Write-one-to-clear strobe for the framing-error flag |
| clr_brk | input | 1 | Write-one-to-clear strobe for the break flag |
| rx_data | output | 8 | Last received data byte |
| rx_bit9 | output | 1 | Last received ninth bit |
| rx_valid | output | 1 | One-cycle strobe for a new frame |
| stat_fe | output | 1 | Sticky framing-error flag |
| stat_brk | output | 1 | Sticky break flag |
| ctrl_top | output | 1 | Top bit of the control register view |
| brk_req | output | 1 | One-cycle break request toward reset control |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit, eight data bits, an eleven-bit break threshold and a two-stage synchronizer. It drives one oversample tick every fourth clock, so a bit takes 64 clocks. That period is long enough to place a one-tick disturbance in mid-bit, a three-tick false start, a ten-bit low that stays under the break threshold, and low periods of twelve and twenty-five bits. All of these run within a short simulation.

// File: rtl/serial_rx9_pkg.sv
package serial_rx9_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // two-of-three vote on the mid-bit samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // number of consecutive low oversample ticks that makes a break
  function automatic int break_ticks(input int nbits, input int osr);
    return nbits * osr;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx9_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_s,
  output logic [NBITS-1:0] frm_data,
  output logic             frm_stop,
  output logic             frm_done,
  output logic             vote_ev,
  output logic             vote_val
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] S_V0   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_V1   = CW'(OSR / 2);
  localparam logic [CW-1:0] S_V2   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] S_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] B_LAST = BW'(NBITS);

  rx_state_e        st;
  logic [CW-1:0]    samp;
  logic [BW-1:0]    bidx;
  logic [NBITS-1:0] shreg;
  logic             s0, s1;

  // internal events brought out for the checker
  assign vote_ev  = tick && (st != ST_HUNT) && (samp == S_V2);
  assign vote_val = vote3(s0, s1, rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_HUNT;
      samp     <= '0;
      bidx     <= '0;
      shreg    <= '0;
      s0       <= 1'b1;
      s1       <= 1'b1;
      frm_data <= '0;
      frm_stop <= 1'b0;
      frm_done <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      if (tick) begin
        if (st == ST_HUNT) begin
          if (!rx_s) begin
            st   <= ST_START;
            samp <= CW'(1);
          end
        end else begin
          if (samp == S_V0) s0 <= rx_s;
          if (samp == S_V1) s1 <= rx_s;
          samp <= (samp == S_LAST) ? '0 : samp + CW'(1);
          if (vote_ev) begin
            case (st)
              ST_START: if (vote_val) st <= ST_HUNT;
              ST_SHIFT: begin
                shreg <= {vote_val, shreg[NBITS-1:1]};
                bidx  <= bidx + BW'(1);
              end
              ST_STOP: begin
                frm_data <= shreg;
                frm_stop <= vote_val;
                frm_done <= 1'b1;
                st       <= ST_HUNT;
              end
              default: st <= ST_HUNT;
            endcase
          end else if (samp == S_LAST) begin
            if (st == ST_START) begin
              st   <= ST_SHIFT;
              bidx <= '0;
            end else if (st == ST_SHIFT && bidx == B_LAST) begin
              st <= ST_STOP;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det
  import serial_rx9_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  output logic brk_hit
);
  localparam int THR  = break_ticks(BRK_BITS, OSR);
  localparam int CNTW = $clog2(THR + 1);
  localparam logic [CNTW-1:0] C_THR  = CNTW'(THR);
  localparam logic [CNTW-1:0] C_PRE  = CNTW'(THR - 1);

  logic [CNTW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      brk_hit <= 1'b0;
    end else begin
      brk_hit <= 1'b0;
      if (tick) begin
        if (rx_s) begin
          low_cnt <= '0;
        end else if (low_cnt != C_THR) begin
          low_cnt <= low_cnt + CNTW'(1);
          if (low_cnt == C_PRE) brk_hit <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx9_brk.sv
module serial_rx9_brk #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int BRK_BITS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              fe_route,
  input  logic              mode_hi,
  input  logic              clr_fe,
  input  logic              clr_brk,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_valid,
  output logic              stat_fe,
  output logic              stat_brk,
  output logic              ctrl_top,
  output logic              brk_req
);
  localparam int NBITS = DATA_W + 1;

  logic             rx_s;
  logic [NBITS-1:0] frm_data;
  logic             frm_stop;
  logic             frm_done;
  logic             vote_ev;
  logic             vote_val;
  logic             brk_hit;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
  );

  rx_frame_fsm #(.OSR(OSR), .NBITS(NBITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s),
    .frm_data(frm_data), .frm_stop(frm_stop), .frm_done(frm_done),
    .vote_ev(vote_ev), .vote_val(vote_val)
  );

  rx_break_det #(.OSR(OSR), .BRK_BITS(BRK_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s), .brk_hit(brk_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_bit9  <= 1'b0;
      rx_valid <= 1'b0;
      stat_fe  <= 1'b0;
      stat_brk <= 1'b0;
      brk_req  <= 1'b0;
    end else begin
      rx_valid <= frm_done;
      brk_req  <= brk_hit;
      if (frm_done) begin
        rx_data <= frm_data[DATA_W-1:0];
        rx_bit9 <= frm_data[NBITS-1];
      end
      if (frm_done && !frm_stop) stat_fe <= 1'b1;
      else if (clr_fe)           stat_fe <= 1'b0;
      if (brk_hit)               stat_brk <= 1'b1;
      else if (clr_brk)          stat_brk <= 1'b0;
    end
  end

  assign ctrl_top = fe_route ? stat_fe : mode_hi;
endmodule

// File: rtl/serial_rx9_chk.sv
module serial_rx9_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic stat_fe,
  input logic stat_brk,
  input logic brk_req,
  input logic clr_fe,
  input logic frm_done,
  input logic vote_ev,
  input logic brk_hit
);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_done_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> rx_valid);
  assert_done_on_vote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(vote_ev));
  assert_fe_with_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_fe) |-> rx_valid);
  assert_fe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_fe && !clr_fe) |=> stat_fe);
  assert_fe_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fe && !frm_done) |=> !stat_fe);
  assert_brk_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> (brk_req && stat_brk));
  assert_brk_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);
endmodule

bind serial_rx9_brk serial_rx9_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .stat_fe(stat_fe),
  .stat_brk(stat_brk), .brk_req(brk_req), .clr_fe(clr_fe),
  .frm_done(frm_done), .vote_ev(vote_ev), .brk_hit(brk_hit)
);

// File: tb/sim_serial_rx9_brk.sv
`timescale 1ns/1ps
module sim_serial_rx9_brk;
  localparam int TDIV = 4;
  localparam int OSR  = 16;
  localparam int BITC = OSR * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic       fe_route = 1'b0;
  logic       mode_hi = 1'b0;
  logic       clr_fe = 1'b0;
  logic       clr_brk = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_valid, stat_fe, stat_brk, ctrl_top, brk_req;

  int n_chk = 0;
  int n_bad = 0;
  int brk_seen = 0;
  int frames = 0;
  bit ignore_frames = 1'b0;
  bit finished = 1'b0;
  logic [9:0] expq[$];   // {fe, bit9, data}
  int tcnt = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick16 <= (tcnt == TDIV - 1);
  end

  serial_rx9_brk u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .fe_route(fe_route), .mode_hi(mode_hi), .clr_fe(clr_fe), .clr_brk(clr_brk),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_valid(rx_valid),
    .stat_fe(stat_fe), .stat_brk(stat_brk), .ctrl_top(ctrl_top), .brk_req(brk_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int nclk);
    @(negedge clk);
    rx_in = v;
    repeat (nclk - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9,
                            input logic stop_v, input bit glitch);
    logic [10:0] bits;
    bits = {stop_v, b9, d, 1'b0};
    expq.push_back({~stop_v, b9, d});
    for (int i = 0; i < 11; i++) begin
      if (glitch && i == 4) begin
        hold(bits[i], 8 * TDIV);
        hold(~bits[i], TDIV);
        hold(bits[i], 7 * TDIV);
      end else begin
        hold(bits[i], BITC);
      end
    end
  endtask

  task automatic pulse_clr(input bit fe);
    @(negedge clk);
    if (fe) clr_fe = 1'b1; else clr_brk = 1'b1;
    @(negedge clk);
    clr_fe = 1'b0;
    clr_brk = 1'b0;
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && brk_req) brk_seen++;
    if (rst_n && rx_valid && !ignore_frames) begin
      frames++;
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected frame", rx_data, 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        check(rx_data == e[7:0], "R1 data", rx_data, e[7:0]);
        check(rx_bit9 == e[8], "R1 ninth bit", rx_bit9, e[8]);
        check(stat_fe == e[9], "R3 framing flag", stat_fe, e[9]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9 reset state
    check(rx_valid == 0 && rx_data == 0 && rx_bit9 == 0, "R9 reset data", rx_data, 0);
    check(stat_fe == 0 && stat_brk == 0 && brk_req == 0, "R9 reset flags",
          {stat_fe, stat_brk, brk_req}, 0);
    rst_n = 1'b1;
    hold(1'b1, 2 * BITC);

    send_frame(8'hA5, 1'b1, 1'b1, 1'b0);
    hold(1'b1, 2 * BITC);
    send_frame(8'h3C, 1'b0, 1'b1, 1'b0);
    hold(1'b1, 2 * BITC);
    // R2 back-to-back frames with one stop bit between
    send_frame(8'h00, 1'b1, 1'b1, 1'b0);
    send_frame(8'hFF, 1'b0, 1'b1, 1'b0);
    send_frame(8'h12, 1'b1, 1'b1, 1'b0);
    hold(1'b1, 2 * BITC);
    // R4 one-tick disturbance at mid-bit
    send_frame(8'h81, 1'b1, 1'b1, 1'b1);
    hold(1'b1, 2 * BITC);
    send_frame(8'h7E, 1'b0, 1'b1, 1'b1);
    hold(1'b1, 2 * BITC);
    check(frames == 7, "R2 frame count", frames, 7);

    // R3 framing error
    send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
    hold(1'b1, 3 * BITC);
    check(stat_fe == 1, "R3 sticky flag", stat_fe, 1);
    // R8 control top bit routing
    fe_route = 1'b0; mode_hi = 1'b0;
    @(negedge clk);
    check(ctrl_top == 0, "R8 mode bit 0", ctrl_top, 0);
    mode_hi = 1'b1;
    @(negedge clk);
    check(ctrl_top == 1, "R8 mode bit 1", ctrl_top, 1);
    fe_route = 1'b1; mode_hi = 1'b0;
    @(negedge clk);
    check(ctrl_top == 1, "R8 routed flag", ctrl_top, 1);
    pulse_clr(1'b1);
    @(negedge clk);
    check(stat_fe == 0, "R9 clear fe", stat_fe, 0);
    check(ctrl_top == 0, "R8 routed cleared", ctrl_top, 0);
    fe_route = 1'b0;

    // R5 false start
    hold(1'b0, 3 * TDIV);
    hold(1'b1, 3 * BITC);
    check(frames == 8 && expq.size() == 0, "R5 false start", frames, 8);

    // R6 below threshold, then a break
    ignore_frames = 1'b1;
    brk_seen = 0;
    hold(1'b0, 10 * BITC);
    hold(1'b1, 12 * BITC);
    check(brk_seen == 0 && stat_brk == 0, "R6 ten bits low", brk_seen, 0);
    hold(1'b0, 25 * BITC);
    hold(1'b1, 12 * BITC);
    check(brk_seen == 1, "R7 single pulse", brk_seen, 1);
    check(stat_brk == 1, "R6 break flag", stat_brk, 1);
    pulse_clr(1'b0);
    @(negedge clk);
    check(stat_brk == 0, "R9 clear brk", stat_brk, 0);
    hold(1'b0, 12 * BITC);
    hold(1'b1, 12 * BITC);
    check(brk_seen == 2 && stat_brk == 1, "R7 rearm", brk_seen, 2);
    pulse_clr(1'b1);
    ignore_frames = 1'b0;

    send_frame(8'hC3, 1'b1, 1'b1, 1'b0);
    hold(1'b1, 2 * BITC);
    check(expq.size() == 0, "R2 queue drained", expq.size(), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule